// File: doc/BRIEF.md
# Dual-Table Snapshot Copy Controller

This block schedules the copying of per-cycle status tables into a shared memory. There are two table instances, one for even communication cycles and one for odd ones. Each has its own lock, valid bit and written flag. These let a host read a consistent snapshot while a copy engine refreshes the tables in later cycles.

An update is triggered by a pulse that marks the start of the network idle phase. The parity of the current cycle selects the table. The engine skips the update if the host holds that parity's lock. Otherwise it streams one memory write per clock to the parity's programmed base address. Host-side controls are provided as discrete pulses and levels: configuration load, lock request, lock release, flag clear and interrupt enables.

Copy behaviour is set by two enables and an option bit. Continuous mode refreshes the tables in every cycle. One-shot mode covers only the next even and odd pair and then switches itself off.

Top module: `snap_copy_ctrl`

## Requirements
- R1: After reset, `mem_we`, both valid bits, both lock bits, both flags, `irq`, `id_en_st` and `dev_en_st` are all 0.
- R2: The programmed entry count is `cfg_count`+1 (N). The enables select what is written:
  - ID enable 1, deviation enable 0: N writes with `mem_dev`=0 at base+i.
  - Both enables 1: N ID writes at base+i, then N writes with `mem_dev`=1 at base+N+i.
  - ID enable 0 (including the reserved combination with only the deviation enable set): no writes, and valid and flag are unchanged.
- R3: A `nit_start` pulse starts an update of the parity given by `cycle_odd` (0 even, 1 odd).
  - The first write occurs in the cycle after the pulse, with one write per cycle and no gaps.
  - The even table uses `cfg_base_even` and the odd table uses `cfg_base_odd`.
  - A `nit_start` that arrives while an update is running is ignored.
- R4: A parity's valid bit is 0 in every cycle of its update. Valid and flag both become 1 in the cycle after the last write.
- R5: If a parity's lock status is 1 when its `nit_start` arrives, no write occurs. That parity's valid and flag keep their values.
- R6: Lock requests and releases:
  - A lock request while the parity is idle sets its lock status in the next cycle.
  - A request made during that parity's update, or in the same cycle as its start, stays pending. It is granted one cycle after the valid bit rises.
  - A release pulse clears the lock status and any pending request in the next cycle.
- R7: A flag clear pulse clears the flag in the next cycle. If a flag is set and cleared in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when (`flag_even` and `irq_en_even`) or (`flag_odd` and `irq_en_odd`).
- R9: One-shot mode and continuous mode:
  - With `cfg_oneshot`=1, both enables clear once the even table and the odd table have each been written or skipped once since configuration.
  - With `cfg_oneshot`=0, the enables stay set.
- R10: A `cfg_we` pulse while an update is running is ignored. The enables, count and bases keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration fields (only while idle) |
| cfg_id_en | input | 1 | ID table copy enable |
| cfg_dev_en | input | 1 | Deviation table copy enable |
| cfg_oneshot | input | 1 | 1: copy next even-odd pair only; 0: continuous |
| cfg_count | input | CNT_W | Entries per table minus one |
| cfg_base_even | input | ADDR_W | Memory base for the even table |
| cfg_base_odd | input | ADDR_W | Memory base for the odd table |
| lock_trig_even | input | 1 | Request lock of even table |
| lock_trig_odd | input | 1 | Request lock of odd table |
| lock_rel_even | input | 1 | Release even lock |
| lock_rel_odd | input | 1 | Release odd lock |
| flag_clr_even | input | 1 | Clear even written flag (write-1) |
| flag_clr_odd | input | 1 | Clear odd written flag (write-1) |
| irq_en_even | input | 1 | Interrupt enable for even flag |
| irq_en_odd | input | 1 | Interrupt enable for odd flag |
| cycle_odd | input | 1 | Current cycle parity, 1 = odd |
| nit_start | input | 1 | Pulse at start of network idle phase |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_dev | output | 1 | 1 = deviation entry, 0 = ID entry |
| id_en_st | output | 1 | Current ID enable |
| dev_en_st | output | 1 | Current deviation enable |
| valid_even | output | 1 | Even table valid |
| valid_odd | output | 1 | Odd table valid |
| lock_even | output | 1 | Even lock held by host |
| lock_odd | output | 1 | Odd lock held by host |
| flag_even | output | 1 | Even table written flag |
| flag_odd | output | 1 | Odd table written flag |
| irq | output | 1 | Interrupt request |

## Verification
Some internal faults show at the ports within the first write cycle: a wrong phase or index in the engine gives an address step or a `mem_dev` edge one cycle too early or late, and a stale valid bit is visible in the write window. A lost pending lock request stays hidden until the cycle after valid rises, where the lock status fails to appear. A miscounted one-shot pair record shows up only after the second table of the pair, as an enable that stays set, or as a write burst on the next idle-phase pulse.

// File: rtl/snap_copy_pkg.sv
package snap_copy_pkg;

    localparam int NUM_PAR = 2;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_ID   = 2'd1,
        ENG_DEV  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic id_en;
        logic dev_en;
        logic oneshot;
    } mode_t;

    // The reserved combination (deviation without ID) copies nothing.
    function automatic logic mode_copies(mode_t m);
        return m.id_en;
    endfunction

    function automatic logic mode_has_dev(mode_t m);
        return m.id_en & m.dev_en;
    endfunction

endpackage

// File: rtl/snap_copy_engine.sv
module snap_copy_engine
    import snap_copy_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  parity_e           go_par,
    input  logic              with_dev,
    input  logic [CNT_W-1:0]  ent_code,
    input  logic [ADDR_W-1:0] base_even,
    input  logic [ADDR_W-1:0] base_odd,
    output logic              busy,
    output parity_e           cur_par,
    output logic              finish,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dev
);

    localparam int EW = CNT_W + 1;

    eng_state_e        state_q;
    logic [EW-1:0]     idx_q;
    logic [EW-1:0]     ent_q;
    logic [ADDR_W-1:0] base_q;
    parity_e           par_q;
    logic              dev_q;
    logic              last_in_phase;

    assign last_in_phase = (idx_q == ent_q - EW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            idx_q   <= '0;
            ent_q   <= '0;
            base_q  <= '0;
            par_q   <= PAR_EVEN;
            dev_q   <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (go) begin
                        state_q <= ENG_ID;
                        idx_q   <= '0;
                        ent_q   <= EW'(ent_code) + EW'(1);
                        par_q   <= go_par;
                        dev_q   <= with_dev;
                        base_q  <= (go_par == PAR_ODD) ? base_odd : base_even;
                    end
                end
                ENG_ID: begin
                    if (last_in_phase) begin
                        idx_q   <= '0;
                        state_q <= dev_q ? ENG_DEV : ENG_IDLE;
                    end else begin
                        idx_q <= idx_q + EW'(1);
                    end
                end
                ENG_DEV: begin
                    if (last_in_phase) begin
                        idx_q   <= '0;
                        state_q <= ENG_IDLE;
                    end else begin
                        idx_q <= idx_q + EW'(1);
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ENG_IDLE);
    assign cur_par = par_q;
    assign mem_we  = busy;
    assign mem_dev = (state_q == ENG_DEV);
    assign finish  = last_in_phase &&
                     (((state_q == ENG_ID) && !dev_q) || (state_q == ENG_DEV));

    always_comb begin
        mem_addr = base_q + ADDR_W'(idx_q);
        if (state_q == ENG_DEV) begin
            mem_addr = mem_addr + ADDR_W'(ent_q);
        end
    end

endmodule

// File: rtl/snap_par_slot.sv
module snap_par_slot (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic busy_here,
    input  logic finish,
    input  logic lock_trig,
    input  logic lock_rel,
    input  logic flag_clr,
    input  logic irq_en,
    output logic lock_st,
    output logic valid,
    output logic flag,
    output logic irq_part
);

    logic pend_q;
    logic want;
    logic blocked;

    assign want    = lock_trig | pend_q;
    assign blocked = busy_here | go;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_st <= 1'b0;
            pend_q  <= 1'b0;
        end else if (lock_rel) begin
            lock_st <= 1'b0;
            pend_q  <= 1'b0;
        end else if (want && !blocked) begin
            lock_st <= 1'b1;
            pend_q  <= 1'b0;
        end else if (want) begin
            pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else if (go) begin
            valid <= 1'b0;
        end else if (finish) begin
            valid <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (finish) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    assign irq_part = flag & irq_en;

endmodule

// File: rtl/snap_mode_ctl.sv
module snap_mode_ctl
    import snap_copy_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  mode_t             cfg_mode,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [ADDR_W-1:0] cfg_base_even,
    input  logic [ADDR_W-1:0] cfg_base_odd,
    input  logic              busy,
    input  logic              done_even,
    input  logic              done_odd,
    output mode_t             mode,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] base_even,
    output logic [ADDR_W-1:0] base_odd
);

    logic seen_even_q;
    logic seen_odd_q;
    logic pair_done;

    assign pair_done = (seen_even_q | done_even) & (seen_odd_q | done_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= '0;
            count       <= '0;
            base_even   <= '0;
            base_odd    <= '0;
            seen_even_q <= 1'b0;
            seen_odd_q  <= 1'b0;
        end else if (cfg_we && !busy) begin
            mode        <= cfg_mode;
            count       <= cfg_count;
            base_even   <= cfg_base_even;
            base_odd    <= cfg_base_odd;
            seen_even_q <= 1'b0;
            seen_odd_q  <= 1'b0;
        end else if (mode.oneshot && mode_copies(mode)) begin
            if (pair_done) begin
                mode.id_en  <= 1'b0;
                mode.dev_en <= 1'b0;
                seen_even_q <= 1'b0;
                seen_odd_q  <= 1'b0;
            end else begin
                seen_even_q <= seen_even_q | done_even;
                seen_odd_q  <= seen_odd_q | done_odd;
            end
        end
    end

endmodule

// File: rtl/snap_copy_ctrl.sv
module snap_copy_ctrl
    import snap_copy_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_id_en,
    input  logic              cfg_dev_en,
    input  logic              cfg_oneshot,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [ADDR_W-1:0] cfg_base_even,
    input  logic [ADDR_W-1:0] cfg_base_odd,
    input  logic              lock_trig_even,
    input  logic              lock_trig_odd,
    input  logic              lock_rel_even,
    input  logic              lock_rel_odd,
    input  logic              flag_clr_even,
    input  logic              flag_clr_odd,
    input  logic              irq_en_even,
    input  logic              irq_en_odd,
    input  logic              cycle_odd,
    input  logic              nit_start,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dev,
    output logic              id_en_st,
    output logic              dev_en_st,
    output logic              valid_even,
    output logic              valid_odd,
    output logic              lock_even,
    output logic              lock_odd,
    output logic              flag_even,
    output logic              flag_odd,
    output logic              irq
);

    mode_t             mode_q;
    mode_t             cfg_mode;
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] base_even_q;
    logic [ADDR_W-1:0] base_odd_q;

    logic              eng_busy;
    parity_e           eng_par;
    logic              eng_finish;
    parity_e           req_par;

    logic [NUM_PAR-1:0] lock_v;
    logic [NUM_PAR-1:0] valid_v;
    logic [NUM_PAR-1:0] flag_v;
    logic [NUM_PAR-1:0] irq_v;
    logic [NUM_PAR-1:0] go_v;
    logic [NUM_PAR-1:0] skip_v;
    logic [NUM_PAR-1:0] fin_v;
    logic [NUM_PAR-1:0] busy_v;
    logic [NUM_PAR-1:0] trig_v;
    logic [NUM_PAR-1:0] rel_v;
    logic [NUM_PAR-1:0] clr_v;
    logic [NUM_PAR-1:0] ien_v;

    logic start_req;
    logic req_locked;
    logic go_any;

    assign cfg_mode = '{id_en: cfg_id_en, dev_en: cfg_dev_en, oneshot: cfg_oneshot};
    assign req_par  = parity_e'(cycle_odd);

    assign start_req  = nit_start & mode_copies(mode_q) & ~eng_busy;
    assign req_locked = lock_v[req_par];
    assign go_any     = start_req & ~req_locked;

    assign trig_v = {lock_trig_odd, lock_trig_even};
    assign rel_v  = {lock_rel_odd, lock_rel_even};
    assign clr_v  = {flag_clr_odd, flag_clr_even};
    assign ien_v  = {irq_en_odd, irq_en_even};

    snap_mode_ctl #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_mode (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_mode     (cfg_mode),
        .cfg_count    (cfg_count),
        .cfg_base_even(cfg_base_even),
        .cfg_base_odd (cfg_base_odd),
        .busy         (eng_busy),
        .done_even    (skip_v[PAR_EVEN] | fin_v[PAR_EVEN]),
        .done_odd     (skip_v[PAR_ODD] | fin_v[PAR_ODD]),
        .mode         (mode_q),
        .count        (count_q),
        .base_even    (base_even_q),
        .base_odd     (base_odd_q)
    );

    snap_copy_engine #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (go_any),
        .go_par   (req_par),
        .with_dev (mode_has_dev(mode_q)),
        .ent_code (count_q),
        .base_even(base_even_q),
        .base_odd (base_odd_q),
        .busy     (eng_busy),
        .cur_par  (eng_par),
        .finish   (eng_finish),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_dev  (mem_dev)
    );

    for (genvar g = 0; g < NUM_PAR; g++) begin : g_slot
        assign go_v[g]   = go_any & (req_par == parity_e'(g));
        assign skip_v[g] = start_req & req_locked & (req_par == parity_e'(g));
        assign fin_v[g]  = eng_finish & (eng_par == parity_e'(g));
        assign busy_v[g] = eng_busy & (eng_par == parity_e'(g));

        snap_par_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .go       (go_v[g]),
            .busy_here(busy_v[g]),
            .finish   (fin_v[g]),
            .lock_trig(trig_v[g]),
            .lock_rel (rel_v[g]),
            .flag_clr (clr_v[g]),
            .irq_en   (ien_v[g]),
            .lock_st  (lock_v[g]),
            .valid    (valid_v[g]),
            .flag     (flag_v[g]),
            .irq_part (irq_v[g])
        );
    end

    assign id_en_st   = mode_q.id_en;
    assign dev_en_st  = mode_q.dev_en;
    assign valid_even = valid_v[PAR_EVEN];
    assign valid_odd  = valid_v[PAR_ODD];
    assign lock_even  = lock_v[PAR_EVEN];
    assign lock_odd   = lock_v[PAR_ODD];
    assign flag_even  = flag_v[PAR_EVEN];
    assign flag_odd   = flag_v[PAR_ODD];
    assign irq        = |irq_v;

endmodule

// File: rtl/snap_copy_chk.sv
module snap_copy_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              cur_par,
    input logic [1:0]        lock_st,
    input logic [1:0]        valid,
    input logic [1:0]        flag,
    input logic              finish,
    input logic [1:0]        flag_clr,
    input logic              mem_we,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] base_e,
    input logic [ADDR_W-1:0] base_o
);

    p_lock_excl_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !lock_st[cur_par]);

    p_valid_low_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !valid[cur_par]);

    p_done_even_r4: assert property (@(posedge clk) disable iff (rst)
        (finish && !cur_par) |=> (valid[0] && flag[0]));

    p_done_odd_r4: assert property (@(posedge clk) disable iff (rst)
        (finish && cur_par) |=> (valid[1] && flag[1]));

    p_flag_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[0] && !(finish && !cur_par)) |=> !flag[0]);

    p_we_busy_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we) |=> ($stable(base_e) && $stable(base_o)));

endmodule

bind snap_copy_ctrl snap_copy_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (eng_busy),
    .cur_par (eng_par),
    .lock_st (lock_v),
    .valid   (valid_v),
    .flag    (flag_v),
    .finish  (eng_finish),
    .flag_clr(clr_v),
    .mem_we  (mem_we),
    .cfg_we  (cfg_we),
    .base_e  (base_even_q),
    .base_o  (base_odd_q)
);

// File: tb/snap_copy_ctrl_tb_top.sv
`timescale 1ns/1ps
module snap_copy_ctrl_tb_top;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 2;
    localparam logic [7:0] BE = 8'h20;
    localparam logic [7:0] BO = 8'h80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_id_en = 0, cfg_dev_en = 0, cfg_oneshot = 0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [ADDR_W-1:0] cfg_base_even = '0, cfg_base_odd = '0;
    logic lock_trig_even = 0, lock_trig_odd = 0, lock_rel_even = 0, lock_rel_odd = 0;
    logic flag_clr_even = 0, flag_clr_odd = 0, irq_en_even = 0, irq_en_odd = 0;
    logic cycle_odd = 0, nit_start = 0;
    logic mem_we, mem_dev, id_en_st, dev_en_st;
    logic [ADDR_W-1:0] mem_addr;
    logic valid_even, valid_odd, lock_even, lock_odd, flag_even, flag_odd, irq;

    snap_copy_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_id_en(cfg_id_en),
        .cfg_dev_en(cfg_dev_en), .cfg_oneshot(cfg_oneshot), .cfg_count(cfg_count),
        .cfg_base_even(cfg_base_even), .cfg_base_odd(cfg_base_odd),
        .lock_trig_even(lock_trig_even), .lock_trig_odd(lock_trig_odd),
        .lock_rel_even(lock_rel_even), .lock_rel_odd(lock_rel_odd),
        .flag_clr_even(flag_clr_even), .flag_clr_odd(flag_clr_odd),
        .irq_en_even(irq_en_even), .irq_en_odd(irq_en_odd),
        .cycle_odd(cycle_odd), .nit_start(nit_start),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_dev(mem_dev),
        .id_en_st(id_en_st), .dev_en_st(dev_en_st),
        .valid_even(valid_even), .valid_odd(valid_odd),
        .lock_even(lock_even), .lock_odd(lock_odd),
        .flag_even(flag_even), .flag_odd(flag_odd), .irq(irq)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nwr = 0;
    int first_cyc = 0;
    int last_cyc = 0;
    logic [ADDR_W-1:0] wr_addr [0:15];
    logic              wr_dev  [0:15];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (nwr < 16) begin
                wr_addr[nwr] = mem_addr;
                wr_dev[nwr]  = mem_dev;
            end
            if (nwr == 0) first_cyc = cyc;
            last_cyc = cyc;
            nwr = nwr + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic cfg(input logic id, input logic dv, input logic os,
                       input int cnt, input logic [7:0] be, input logic [7:0] bo);
        cfg_id_en = id; cfg_dev_en = dv; cfg_oneshot = os;
        cfg_count = CNT_W'(cnt); cfg_base_even = be; cfg_base_odd = bo;
        cfg_we = 1; tick; cfg_we = 0;
    endtask

    int start_cyc = 0;
    logic v_during = 0;

    task automatic run_upd(input logic par);
        nwr = 0;
        cycle_odd = par;
        start_cyc = cyc;
        nit_start = 1; tick; nit_start = 0;
        v_during = par ? valid_odd : valid_even;
        repeat (12) tick;
    endtask

    task automatic clr_flags;
        flag_clr_even = 1; flag_clr_odd = 1; tick;
        flag_clr_even = 0; flag_clr_odd = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [1:0] vexp;
        vexp = 2'b00;
        repeat (3) tick;
        rst = 0;
        tick;
        // R1 reset state
        check("R1 mem_we", mem_we, 0);
        check("R1 valid", {valid_odd, valid_even}, 0);
        check("R1 lock", {lock_odd, lock_even}, 0);
        check("R1 flag", {flag_odd, flag_even}, 0);
        check("R1 irq", irq, 0);
        check("R1 enables", {id_en_st, dev_en_st}, 0);

        // R2/R3/R4 sweep over count, mode and parity (continuous mode)
        for (int cnt = 0; cnt < 4; cnt++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 2; p++) begin
                    int ent, total, bad;
                    logic [7:0] base;
                    logic vnow, fnow;
                    ent   = cnt + 1;
                    total = m[0] ? ent * (m[1] ? 2 : 1) : 0;
                    base  = p ? BO : BE;
                    cfg(m[0], m[1], 1'b0, cnt, BE, BO);
                    run_upd(p[0]);
                    check($sformatf("R2 count c%0d m%0d p%0d", cnt, m, p), nwr, total);
                    bad = 0;
                    for (int k = 0; k < total && k < nwr; k++) begin
                        if (wr_addr[k] != base + 8'(k)) bad++;
                        if (wr_dev[k] != (k >= ent)) bad++;
                    end
                    check("R2 addr/kind sequence", bad, 0);
                    if (total > 0) begin
                        check("R3 first write timing", first_cyc, start_cyc + 1);
                        check("R3 contiguous", last_cyc - first_cyc, total - 1);
                        check("R4 valid low during update", v_during, 0);
                        vexp[p] = 1'b1;
                    end
                    vnow = p ? valid_odd : valid_even;
                    fnow = p ? flag_odd : flag_even;
                    check("R4 valid after update", vnow, vexp[p]);
                    check("R4 flag after update", fnow, total > 0);
                    check("R9 continuous keeps enable", id_en_st, m[0]);
                    clr_flags;
                end
            end
        end

        // R5/R6 lock on idle parity, skip
        cfg(1, 0, 0, 1, BE, BO);
        run_upd(0);
        clr_flags;
        lock_trig_even = 1; tick; lock_trig_even = 0;
        check("R6 lock granted when idle", lock_even, 1);
        run_upd(0);
        check("R5 skipped writes", nwr, 0);
        check("R5 valid kept", valid_even, 1);
        check("R5 flag not set", flag_even, 0);
        lock_rel_even = 1; tick; lock_rel_even = 0;
        check("R6 release", lock_even, 0);

        // R6 pending request during update
        nwr = 0;
        cycle_odd = 1; nit_start = 1; tick; nit_start = 0;
        lock_trig_odd = 1; tick; lock_trig_odd = 0;
        check("R6 not granted while busy", lock_odd, 0);
        for (int w = 0; w < 20 && !valid_odd; w++) tick;
        check("R6 still pending at valid rise", lock_odd, 0);
        tick;
        check("R6 granted after update", lock_odd, 1);
        run_upd(1);
        check("R5 odd skipped", nwr, 0);
        lock_rel_odd = 1; tick; lock_rel_odd = 0;
        check("R6 odd release", lock_odd, 0);

        // R6 request in same cycle as start
        nwr = 0;
        cycle_odd = 0; nit_start = 1; lock_trig_even = 1; tick;
        nit_start = 0; lock_trig_even = 0;
        check("R6 same-cycle not granted", lock_even, 0);
        for (int w = 0; w < 20 && !valid_even; w++) tick;
        check("R6 same-cycle update ran", nwr, 2);
        tick;
        check("R6 same-cycle granted later", lock_even, 1);
        lock_rel_even = 1; tick; lock_rel_even = 0;
        clr_flags;

        // R7 set wins over clear
        cycle_odd = 0; nit_start = 1; tick; nit_start = 0;
        tick;                     // write 0 seen; write 1 in this cycle next
        flag_clr_even = 1; tick; flag_clr_even = 0;
        check("R7 set wins", flag_even, 1);
        // R8 irq gating
        check("R8 irq masked", irq, 0);
        irq_en_even = 1; #1;
        check("R8 irq even", irq, 1);
        irq_en_even = 0; irq_en_odd = 1; #1;
        check("R8 irq odd flag clear", irq, 0);
        irq_en_even = 1;
        flag_clr_even = 1; tick; flag_clr_even = 0;
        check("R7 clear", flag_even, 0);
        check("R8 irq after clear", irq, 0);
        irq_en_even = 0; irq_en_odd = 0;

        // R9 one-shot pair
        cfg(1, 0, 1, 0, BE, BO);
        run_upd(0);
        check("R9 oneshot even write", nwr, 1);
        check("R9 enable held after even", id_en_st, 1);
        run_upd(1);
        check("R9 oneshot odd write", nwr, 1);
        check("R9 enable cleared", id_en_st, 0);
        run_upd(0);
        check("R9 no copy after pair", nwr, 0);
        clr_flags;

        // R9 one-shot with a skipped table
        cfg(1, 1, 1, 0, BE, BO);
        lock_trig_even = 1; tick; lock_trig_even = 0;
        run_upd(0);
        check("R9 skip counts", nwr, 0);
        check("R9 enable after skip", id_en_st, 1);
        run_upd(1);
        check("R9 odd with dev", nwr, 2);
        check("R9 dev enable cleared", {id_en_st, dev_en_st}, 0);
        lock_rel_even = 1; tick; lock_rel_even = 0;
        clr_flags;

        // R10 config ignored while busy
        cfg(1, 0, 0, 3, BE, BO);
        nwr = 0;
        cycle_odd = 0; nit_start = 1; tick; nit_start = 0;
        cfg_id_en = 0; cfg_base_even = 8'h40; cfg_count = '0;
        cfg_we = 1; tick; cfg_we = 0;
        repeat (10) tick;
        check("R10 enable kept", id_en_st, 1);
        run_upd(0);
        check("R10 count kept", nwr, 4);
        check("R10 base kept", wr_addr[0], BE);
        clr_flags;

        // R3 nit_start during update ignored
        cfg(1, 1, 0, 3, BE, BO);
        nwr = 0;
        cycle_odd = 0; nit_start = 1; tick; nit_start = 0;
        tick; tick;
        cycle_odd = 1; nit_start = 1; tick; nit_start = 0;
        repeat (14) tick;
        check("R3 overlap write count", nwr, 8);
        check("R3 overlap last addr", wr_addr[7], BE + 8'd7);
        check("R3 odd untouched", flag_odd, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule